// File: doc/BRIEF.md
# Router Output Channel Synchronizer

This block sits between a packet router's controller and its three output FIFOs. The controller flags the header byte of a new packet with `addr_detect`. On that clock edge the block stores the 2-bit destination carried on `dest_addr`. It keeps that destination until the next header arrives. While the destination is held, the controller's single write request is steered to the write enable of the chosen FIFO. The full flag of the same FIFO is returned on `sel_full` so the controller can stall.

On the output side, each channel reports `out_valid` whenever its FIFO holds data. Each channel also has a read watchdog. When a channel has data waiting and its consumer does not read for a fixed number of cycles, the watchdog emits a one-cycle `soft_rst` for that channel. The FIFO can use that pulse to discard the stale packet.

All pins are plain level control and status signals: no data passes through this block, so it has no valid/ready stream port and no back-pressure rules. Reset is synchronous and active low.

Top module: `router_chan_sync`

## Requirements
- R1: `dest_addr` is captured on a rising clock edge where `addr_detect` is 1. The new value steers `wr_en` and `sel_full` from the following cycle on.
- R2: `sel_full` equals `fifo_full[0]`, `fifo_full[1]` or `fifo_full[2]` when the held address is 2'b00, 2'b01 or 2'b10 respectively. It is 0 when the held address is 2'b11.
- R3: While `addr_detect` is 0, the held address does not change, whatever `dest_addr` does.
- R4: `out_valid[i]` is 1 exactly when `fifo_empty[i]` is 0. It is combinational, with no latency.
- R5: `wr_en[i]` is 1 only when `wr_req` is 1 and the held address equals i. Bit 0 is selected by 2'b00, bit 1 by 2'b01 and bit 2 by 2'b10. `wr_en` is combinational on `wr_req`.
- R6: When the held address is 2'b11, no bit of `wr_en` is ever set.
- R7: A channel's `soft_rst[i]` is high in the cycle after the TIMEOUT-th consecutive clock edge at which `out_valid[i]` was 1 and `rd_en[i]` was 0. TIMEOUT defaults to 30.
- R8: A clock edge at which `rd_en[i]` is 1 or `out_valid[i]` is 0 restarts channel i's count from zero. Such an edge also leaves `soft_rst[i]` low in the next cycle.
- R9: `soft_rst[i]` is high for exactly one cycle. Counting restarts at zero, so an unread channel pulses again every TIMEOUT edges.
- R10: A clock edge with `rst_n` low sets the held address to 2'b00, clears all counts and drives all `soft_rst` bits low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_detect | input | 1 | Controller flags a header; capture `dest_addr` |
| dest_addr | input | 2 | Destination channel of the incoming packet |
| wr_req | input | 1 | Controller's single FIFO write request |
| rd_en | input | 3 | Per-channel consumer read enables |
| fifo_empty | input | 3 | Per-channel FIFO empty flags |
| fifo_full | input | 3 | Per-channel FIFO full flags |
| sel_full | output | 1 | Full flag of the addressed FIFO |
| wr_en | output | 3 | Steered per-FIFO write enables |
| out_valid | output | 3 | Per-channel data-available indication |
| soft_rst | output | 3 | Per-channel one-cycle read-timeout pulse |

## Verification
The bound checker holds on every cycle to the properties that can be stated locally:
- `wr_en` is never more than one-hot, and it stays silent without a request.
- `sel_full` agrees with the full flag of whichever channel is being written.
- A header carrying address 2'b11 blocks all writes on the next cycle.
- A soft-reset pulse never lasts two cycles.
- A soft-reset pulse never follows a read or an empty FIFO.

Only the bench scenarios can show the exact 30-edge timing of the watchdog and the repeat after an ignored pulse. The same holds for the address staying put across many cycles while `dest_addr` wanders. The bench's reference model checks both cycle by cycle.

// File: rtl/router_sync_pkg.sv
package router_sync_pkg;
  localparam int ADDR_W = 2;
  localparam int CH_NUM = 3;
  typedef logic [ADDR_W-1:0] dest_t;
  typedef logic [CH_NUM-1:0] ch_vec_t;
endpackage

// File: rtl/dest_latch.sv
module dest_latch
  import router_sync_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  capture,
  input  dest_t addr_in,
  output dest_t addr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       addr_q <= '0;
    else if (capture) addr_q <= addr_in;
  end
endmodule

// File: rtl/write_steer.sv
module write_steer
  import router_sync_pkg::*;
(
  input  dest_t   addr,
  input  logic    wr_req,
  input  ch_vec_t full_in,
  output ch_vec_t wr_en,
  output logic    sel_full
);
  for (genvar i = 0; i < CH_NUM; i++) begin : g_sel
    assign wr_en[i] = wr_req && (addr == ADDR_W'(i));
  end

  always_comb begin
    sel_full = 1'b0;
    for (int i = 0; i < CH_NUM; i++)
      if (addr == ADDR_W'(i)) sel_full = full_in[i];
  end
endmodule

// File: rtl/chan_watchdog.sv
module chan_watchdog #(
  parameter int LIMIT = 30,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic rd,
  output logic soft_rst
);
  logic [CW-1:0] cnt;
  logic          hit;

  assign hit = (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      soft_rst <= 1'b0;
    end else if (!valid || rd) begin
      cnt      <= '0;
      soft_rst <= 1'b0;
    end else if (hit) begin
      cnt      <= '0;
      soft_rst <= 1'b1;
    end else begin
      cnt      <= cnt + 1'b1;
      soft_rst <= 1'b0;
    end
  end
endmodule

// File: rtl/router_chan_sync.sv
module router_chan_sync
  import router_sync_pkg::*;
#(
  parameter int TIMEOUT = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_detect,
  input  logic [1:0] dest_addr,
  input  logic       wr_req,
  input  logic [2:0] rd_en,
  input  logic [2:0] fifo_empty,
  input  logic [2:0] fifo_full,
  output logic       sel_full,
  output logic [2:0] wr_en,
  output logic [2:0] out_valid,
  output logic [2:0] soft_rst
);
  dest_t addr_q;

  dest_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (addr_detect),
    .addr_in (dest_addr),
    .addr_q  (addr_q)
  );

  write_steer u_steer (
    .addr     (addr_q),
    .wr_req   (wr_req),
    .full_in  (fifo_full),
    .wr_en    (wr_en),
    .sel_full (sel_full)
  );

  assign out_valid = ~fifo_empty;

  for (genvar c = 0; c < CH_NUM; c++) begin : g_wd
    chan_watchdog #(.LIMIT(TIMEOUT)) u_wd (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (out_valid[c]),
      .rd       (rd_en[c]),
      .soft_rst (soft_rst[c])
    );
  end
endmodule

// File: rtl/router_chan_sync_chk.sv
module router_chan_sync_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr_detect,
  input logic [1:0] dest_addr,
  input logic       wr_req,
  input logic [2:0] rd_en,
  input logic [2:0] fifo_empty,
  input logic [2:0] fifo_full,
  input logic       sel_full,
  input logic [2:0] wr_en,
  input logic [2:0] out_valid,
  input logic [2:0] soft_rst
);
  a_r5_wr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  a_r5_no_req_no_wr: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |-> wr_en == 3'b000);

  a_r6_addr3_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_detect && dest_addr == 2'b11) |=> wr_en == 3'b000);

  a_r2_idle_full_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_en == 3'b000) |-> !sel_full);

  for (genvar i = 0; i < 3; i++) begin : g_ch
    a_r2_full_matches: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[i] |-> sel_full == fifo_full[i]);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst[i] |=> !soft_rst[i]);

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en[i] |=> !soft_rst[i]);

    a_r8_empty_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_empty[i] || !out_valid[i]) |=> !soft_rst[i]);
  end
endmodule

bind router_chan_sync router_chan_sync_chk u_chk (.*);

// File: tb/router_chan_sync_tb.sv
`timescale 1ns/1ps
module router_chan_sync_tb;
  logic       clk = 0;
  logic       rst_n;
  logic       addr_detect;
  logic [1:0] dest_addr;
  logic       wr_req;
  logic [2:0] rd_en, fifo_empty, fifo_full;
  logic       sel_full;
  logic [2:0] wr_en, out_valid, soft_rst;

  int total = 0, bad = 0;
  int m_addr;
  int m_cnt [3];
  bit m_soft [3];

  always #5 clk = ~clk;

  router_chan_sync u_dut (.*);

  // behavioural reference, updated at each edge from inputs held stable
  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0;
      foreach (m_cnt[c]) begin m_cnt[c] = 0; m_soft[c] = 0; end
    end else begin
      if (addr_detect) m_addr = dest_addr;
      foreach (m_cnt[c]) begin
        if (fifo_empty[c] || rd_en[c]) begin m_cnt[c] = 0; m_soft[c] = 0; end
        else if (m_cnt[c] == 29) begin m_cnt[c] = 0; m_soft[c] = 1; end
        else begin m_cnt[c] = m_cnt[c] + 1; m_soft[c] = 0; end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int ew, ef;
    ew = 0;
    if (wr_req && m_addr < 3) ew = 1 << m_addr;
    ef = (m_addr < 3) ? int'(fifo_full[m_addr]) : 0;
    chk("R5/R6/R1/R3 wr_en", wr_en, ew);
    chk("R2 sel_full", sel_full, ef);
    chk("R4 out_valid", out_valid, ~fifo_empty & 3'b111);
    for (int c = 0; c < 3; c++)
      chk($sformatf("R7/R8/R9 soft_rst%0d", c), soft_rst[c], m_soft[c]);
  endtask

  task automatic step(bit det, int a, bit wq, int rd, int emp, int ful);
    @(negedge clk);
    addr_detect = det; dest_addr = a[1:0]; wr_req = wq;
    rd_en = rd[2:0]; fifo_empty = emp[2:0]; fifo_full = ful[2:0];
    #1 compare_all();
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; addr_detect = 0; dest_addr = 0; wr_req = 0;
    rd_en = 0; fifo_empty = 3'b111; fifo_full = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10 soft_rst after reset", soft_rst, 0);
    chk("R10 wr_en addr0 after reset", wr_en, 0);
    rst_n = 1;

    // R1/R2/R5: each address, with full patterns
    for (int a = 0; a < 4; a++) begin
      step(1, a, 0, 0, 7, 0);
      step(0, 0, 1, 0, 7, 3'b101);
      step(0, 3, 1, 0, 7, 3'b010);
      step(0, 1, 1, 0, 7, 3'b111);
      step(0, 2, 0, 0, 7, 3'b111);
    end
    // R3: held across wandering dest_addr
    step(1, 2, 1, 0, 7, 0);
    for (int k = 0; k < 8; k++) step(0, k, 1, 0, 7, 3'b100);
    // R6: address 3 blocks
    step(1, 3, 1, 0, 7, 7);
    for (int k = 0; k < 4; k++) step(0, 0, 1, 0, 7, 7);

    // R4/R7: channel 1 waits 35 cycles unread
    for (int k = 0; k < 35; k++) step(0, 0, 0, 0, 3'b101, 0);
    // R8: read at 20 restarts
    for (int k = 0; k < 45; k++) step(0, 0, 0, (k == 20) ? 2 : 0, 3'b101, 0);
    // R8: valid drop restarts, all channels
    for (int k = 0; k < 45; k++) step(0, 0, 0, 0, (k == 15) ? 7 : 0, 0);
    // R9: continuous wait, repeat pulses
    for (int k = 0; k < 70; k++) step(0, 0, 0, 0, 3'b011, 0);

    // R10: reset mid-count
    for (int k = 0; k < 20; k++) step(0, 0, 0, 0, 0, 0);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int k = 0; k < 32; k++) step(0, 0, 0, 0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule